// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a memory-mapped mailbox between a host processor and an embedded controller. The host loads up to 16 bytes of payload into a write-only buffer, then issues one 32-bit write to the command register. That single write starts the transaction. It also carries a packed command code, a 4-bit sub-command, a payload byte count and a flag that requests an interrupt on completion. The write rings a one-cycle doorbell toward the controller. The controller reads the latched command fields and the payload words through dedicated ports. It writes its response words and an 8-bit error code through its own write ports, then signals done, optionally with a failure flag.

A state machine sequences each transaction. It has three states: `ST_IDLE` (no transaction), `ST_RING` (the one cycle in which the doorbell is high) and `ST_WAIT` (waiting for the controller). There are four transitions:
- accept: from `ST_IDLE` to `ST_RING` on a command write.
- settle: from `ST_RING` to `ST_WAIT` when done is absent.
- finish: from `ST_RING` or `ST_WAIT` back to `ST_IDLE` on done.
- stay: every other case.

The host polls a read-only status word. It can also take a single-cycle completion interrupt that needs no clearing, and it collects the response by reading the response buffer as bytes or as 32-bit words.

Top module: `hc_mailbox`

## Requirements
- R1: After reset, busy, the error flag, the error code, the latched sub-command, both buffers, the doorbell and the host interrupt are all zero. A status read then returns only the initiator id in bits [15:8].
- R2: A host write to offset 0x00 while idle raises `ctl_doorbell` for exactly one cycle, the cycle after the write. Busy (status bit 0) is set from that cycle on.
- R3: The command word is decoded as follows: command code [7:0], interrupt-on-completion [8], sub-command [15:12], payload size [23:16]. Bits [11:9] and [31:24] are ignored. The code, sub-command and size are presented unchanged on the controller command ports for the whole transaction.
- R4: A command write that arrives while busy is ignored. It raises no doorbell, and the controller command ports and the status sub-command keep their values.
- R5: A host word write to offset 0x80+4k (k = 0..3) stores the word in payload slot k. The controller reads the slot on `ctl_pay_data` by driving `ctl_pay_idx` = k.
- R6: A status read at offset 0x04 returns the following layout: [0] busy, [1] error, [3:2] zero, [7:4] sub-command, [15:8] initiator id, [23:16] error code, [31:24] zero. Read data appears on `host_rdata` with `host_rvalid` one cycle after `host_rd_en`.
- R7: When `ctl_done` is high while busy, busy clears on that clock edge and the error bit takes the value of `ctl_fail`. An error code written through `ctl_err_we` while busy is reported in status [23:16].
- R8: If the accepted command had bit 8 set, `host_irq` is high for exactly the one cycle after the done cycle. Otherwise it stays low.
- R9: A response word written through `ctl_rsp_we` into slot k reads back at offset 0x90+4k as a word. With `host_rd_byte` high, a read at 0x90+n returns byte n of the buffer (little-endian within each word) in bits [7:0], with zeros above it.
- R10: Accepting a new command clears the error bit and the error code.
- R11: `ctl_done` while idle changes no status and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_rd_en | input | 1 | Host register read strobe |
| host_rd_byte | input | 1 | Read as a single byte (response buffer) |
| host_addr | input | 8 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle after the read strobe |
| host_rvalid | output | 1 | Read data valid |
| host_irq | output | 1 | Completion interrupt pulse |
| ctl_doorbell | output | 1 | New-command pulse to the controller |
| ctl_cmd_code | output | 8 | Latched command code |
| ctl_cmd_sub | output | 4 | Latched sub-command id |
| ctl_cmd_size | output | 8 | Latched payload byte count |
| ctl_pay_idx | input | 2 | Payload word index to read |
| ctl_pay_data | output | 32 | Payload word at ctl_pay_idx |
| ctl_rsp_we | input | 1 | Response word write strobe |
| ctl_rsp_idx | input | 2 | Response word index |
| ctl_rsp_data | input | 32 | Response word |
| ctl_err_we | input | 1 | Error code write strobe |
| ctl_err_code | input | 8 | Error code value |
| ctl_done | input | 1 | Controller finished the command |
| ctl_fail | input | 1 | Command failed (sampled with done) |

## Verification
The embedded properties check the following on every cycle:
- the doorbell is a lone one-cycle pulse;
- an idle command write always leads to busy;
- a write made while busy never rings the doorbell;
- done while busy always clears busy;
- idle done is inert;
- the host interrupt never fires without a done accepted in the previous cycle.

Only the bench's scenarios can show the data-level behaviour:
- the bit positions of the command and status words;
- the payload and response words reaching the right slots;
- byte-lane selection in the response buffer;
- error latching and its clearing by the next command;
- the interrupt depending on the requested flag.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int OFF_CMD  = 'h00;
    localparam int OFF_STAT = 'h04;
    localparam int OFF_WBUF = 'h80;
    localparam int OFF_RBUF = 'h90;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RING = 2'd1,
        ST_WAIT = 2'd2
    } mbx_state_e;

    typedef struct packed {
        logic [7:0] size;
        logic [3:0] sub;
        logic       ioc;
        logic [7:0] code;
    } mbx_cmd_t;

endpackage

// File: rtl/mbx_fsm.sv
module mbx_fsm
    import mbx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  mbx_cmd_t   cmd_in,
    input  logic       ctl_done,
    input  logic       ctl_fail,
    input  logic       err_we,
    input  logic [7:0] err_code_in,
    output logic       busy,
    output logic       doorbell,
    output mbx_cmd_t   cmd_q,
    output logic       err_bit,
    output logic [7:0] err_code,
    output logic       host_irq
);

    mbx_state_e state, nxt;
    logic       accept;
    logic       finish;

    assign accept = cmd_wr && (state == ST_IDLE);
    assign finish = ctl_done && (state != ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state and state-decoded outputs
    always_comb begin
        nxt      = state;
        busy     = 1'b0;
        doorbell = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (accept) nxt = ST_RING;
            end
            ST_RING: begin
                busy     = 1'b1;
                doorbell = 1'b1;
                nxt      = ctl_done ? ST_IDLE : ST_WAIT;
            end
            ST_WAIT: begin
                busy = 1'b1;
                if (ctl_done) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // transaction datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            err_bit  <= 1'b0;
            err_code <= 8'h00;
            host_irq <= 1'b0;
        end else begin
            host_irq <= finish && cmd_q.ioc;
            if (accept) begin
                cmd_q    <= cmd_in;
                err_bit  <= 1'b0;
                err_code <= 8'h00;
            end else begin
                if (err_we && busy) err_code <= err_code_in;
                if (finish)         err_bit  <= ctl_fail;
            end
        end
    end

    // R2
    doorbell_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        doorbell |=> !doorbell);

    // R2
    go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy) |=> (busy && doorbell));

    // R4
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy) |=> !doorbell);

    // R7
    done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctl_done) |=> !busy);

    // R8
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> ($past(ctl_done) && $past(busy)));

    // R11
    idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ctl_done && !cmd_wr) |=> (!busy && !host_irq));

endmodule

// File: rtl/mbx_wbuf.sv
module mbx_wbuf #(
    parameter int WORDS = 4,
    parameter int IW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [31:0]   wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [31:0]   rd_data
);

    logic [31:0] slot [WORDS];

    for (genvar k = 0; k < WORDS; k++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              slot[k] <= '0;
            else if (wr_en && wr_idx == IW'(k))      slot[k] <= wr_data;
        end
    end

    assign rd_data = slot[rd_idx];

endmodule

// File: rtl/mbx_rbuf.sv
module mbx_rbuf #(
    parameter int WORDS = 4,
    parameter int IW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [31:0]   wr_data,
    input  logic [IW+1:0] rd_byte_addr,
    input  logic          rd_byte,
    output logic [31:0]   rd_data
);

    logic [31:0] slot [WORDS];
    logic [31:0] word_sel;
    logic [1:0]  lane;

    for (genvar k = 0; k < WORDS; k++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              slot[k] <= '0;
            else if (wr_en && wr_idx == IW'(k))      slot[k] <= wr_data;
        end
    end

    assign word_sel = slot[rd_byte_addr[IW+1:2]];
    assign lane     = rd_byte_addr[1:0];

    always_comb begin
        if (rd_byte) rd_data = {24'h0, word_sel[8*lane +: 8]};
        else         rd_data = word_sel;
    end

endmodule

// File: rtl/hc_mailbox.sv
module hc_mailbox
    import mbx_pkg::*;
#(
    parameter int          BUF_BYTES = 16,
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  INIT_ID   = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic              host_rd_en,
    input  logic              host_rd_byte,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              host_rvalid,
    output logic              host_irq,
    output logic              ctl_doorbell,
    output logic [7:0]        ctl_cmd_code,
    output logic [3:0]        ctl_cmd_sub,
    output logic [7:0]        ctl_cmd_size,
    input  logic [1:0]        ctl_pay_idx,
    output logic [31:0]       ctl_pay_data,
    input  logic              ctl_rsp_we,
    input  logic [1:0]        ctl_rsp_idx,
    input  logic [31:0]       ctl_rsp_data,
    input  logic              ctl_err_we,
    input  logic [7:0]        ctl_err_code,
    input  logic              ctl_done,
    input  logic              ctl_fail
);

    localparam int WORDS = BUF_BYTES / 4;
    localparam int IW    = $clog2(WORDS);
    localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(OFF_CMD);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STAT);
    localparam logic [ADDR_W-1:0] WB_LO   = ADDR_W'(OFF_WBUF);
    localparam logic [ADDR_W-1:0] WB_HI   = ADDR_W'(OFF_WBUF + BUF_BYTES);
    localparam logic [ADDR_W-1:0] RB_LO   = ADDR_W'(OFF_RBUF);
    localparam logic [ADDR_W-1:0] RB_HI   = ADDR_W'(OFF_RBUF + BUF_BYTES);

    logic        cmd_wr;
    logic        wb_wr;
    logic        in_rbuf;
    mbx_cmd_t    cmd_in;
    mbx_cmd_t    cmd_q;
    logic        busy;
    logic        err_bit;
    logic [7:0]  err_code;
    logic [31:0] status_word;
    logic [31:0] rb_data;
    logic [31:0] rd_mux;
    logic        unused_bits;

    assign cmd_wr  = host_wr_en && (host_addr == A_CMD);
    assign wb_wr   = host_wr_en && (host_addr >= WB_LO) && (host_addr < WB_HI);
    assign in_rbuf = (host_addr >= RB_LO) && (host_addr < RB_HI);

    assign cmd_in.size = host_wdata[23:16];
    assign cmd_in.sub  = host_wdata[15:12];
    assign cmd_in.ioc  = host_wdata[8];
    assign cmd_in.code = host_wdata[7:0];
    assign unused_bits = ^{host_wdata[31:24], host_wdata[11:9]};

    mbx_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr      (cmd_wr),
        .cmd_in      (cmd_in),
        .ctl_done    (ctl_done),
        .ctl_fail    (ctl_fail),
        .err_we      (ctl_err_we),
        .err_code_in (ctl_err_code),
        .busy        (busy),
        .doorbell    (ctl_doorbell),
        .cmd_q       (cmd_q),
        .err_bit     (err_bit),
        .err_code    (err_code),
        .host_irq    (host_irq)
    );

    mbx_wbuf #(.WORDS(WORDS), .IW(IW)) u_wbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wb_wr),
        .wr_idx  (host_addr[IW+1:2]),
        .wr_data (host_wdata),
        .rd_idx  (ctl_pay_idx[IW-1:0]),
        .rd_data (ctl_pay_data)
    );

    mbx_rbuf #(.WORDS(WORDS), .IW(IW)) u_rbuf (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (ctl_rsp_we),
        .wr_idx       (ctl_rsp_idx[IW-1:0]),
        .wr_data      (ctl_rsp_data),
        .rd_byte_addr (host_addr[IW+1:0]),
        .rd_byte      (host_rd_byte),
        .rd_data      (rb_data)
    );

    assign ctl_cmd_code = cmd_q.code;
    assign ctl_cmd_sub  = cmd_q.sub;
    assign ctl_cmd_size = cmd_q.size;

    assign status_word = {8'h00, err_code, INIT_ID, cmd_q.sub, 2'b00, err_bit, busy};

    always_comb begin
        if (host_addr == A_STAT) rd_mux = status_word;
        else if (in_rbuf)        rd_mux = rb_data;
        else                     rd_mux = 32'h0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_rvalid <= 1'b0;
            host_rdata  <= 32'h0;
        end else begin
            host_rvalid <= host_rd_en;
            if (host_rd_en) host_rdata <= rd_mux;
        end
    end

    // R6
    rvalid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> $past(host_rd_en));

endmodule

// File: tb/sim_hc_mailbox.sv
module sim_hc_mailbox;

    localparam int         CLK_PERIOD = 10;
    localparam logic [7:0] INIT = 8'h5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0, host_rd_en = 1'b0, host_rd_byte = 1'b0;
    logic [7:0]  host_addr = 8'h0;
    logic [31:0] host_wdata = 32'h0;
    logic [31:0] host_rdata;
    logic        host_rvalid, host_irq, ctl_doorbell;
    logic [7:0]  ctl_cmd_code, ctl_cmd_size;
    logic [3:0]  ctl_cmd_sub;
    logic [1:0]  ctl_pay_idx = 2'd0;
    logic [31:0] ctl_pay_data;
    logic        ctl_rsp_we = 1'b0;
    logic [1:0]  ctl_rsp_idx = 2'd0;
    logic [31:0] ctl_rsp_data = 32'h0;
    logic        ctl_err_we = 1'b0;
    logic [7:0]  ctl_err_code = 8'h0;
    logic        ctl_done = 1'b0, ctl_fail = 1'b0;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] rsp [4] = '{32'h44332211, 32'h88776655, 32'hCCBBAA99, 32'h00FFEEDD};

    hc_mailbox #(.INIT_ID(INIT)) u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor: compares each returned read with the queued expectation
    always @(negedge clk) begin
        if (host_rvalid) begin
            if (exp_q.size() == 0) chk("R6 unexpected read", 32'h1, 32'h0);
            else chk(tag_q.pop_front(), host_rdata, exp_q.pop_front());
        end
    end

    task automatic host_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr_en = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic host_read(input logic [7:0] a, input logic bytemode,
                             input logic [31:0] exp, input string tag);
        @(negedge clk);
        host_rd_en = 1'b1; host_addr = a; host_rd_byte = bytemode;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        host_rd_en = 1'b0; host_rd_byte = 1'b0;
    endtask

    task automatic ctl_finish(input logic fail, output logic irq_seen, output logic irq_after);
        @(negedge clk);
        ctl_done = 1'b1; ctl_fail = fail;
        @(negedge clk);
        ctl_done = 1'b0; ctl_fail = 1'b0;
        irq_seen = host_irq;
        @(negedge clk);
        irq_after = host_irq;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic i1, i2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 doorbell", {31'h0, ctl_doorbell}, 32'h0);
        chk("R1 irq", {31'h0, host_irq}, 32'h0);
        chk("R1 payload", ctl_pay_data, 32'h0);
        host_read(8'h04, 1'b0, {16'h0, INIT, 8'h00}, "R1 status");
        host_read(8'h9C, 1'b0, 32'h0, "R1 rbuf");

        // R5 payload slots
        for (int k = 0; k < 4; k++) host_write(8'h80 + 8'(4*k), 32'hA0B0C000 + 32'(k));
        for (int k = 0; k < 4; k++) begin
            ctl_pay_idx = 2'(k);
            #1;
            chk("R5 payload slot", ctl_pay_data, 32'hA0B0C000 + 32'(k));
        end

        // R2 R3 accepted command with ioc, junk in reserved bits
        host_write(8'h00, 32'hFF0C2F80);
        chk("R2 doorbell high", {31'h0, ctl_doorbell}, 32'h1);
        chk("R3 code", {24'h0, ctl_cmd_code}, 32'h80);
        chk("R3 sub", {28'h0, ctl_cmd_sub}, 32'h2);
        chk("R3 size", {24'h0, ctl_cmd_size}, 32'h0C);
        @(negedge clk);
        chk("R2 doorbell one cycle", {31'h0, ctl_doorbell}, 32'h0);
        host_read(8'h04, 1'b0, {16'h0, INIT, 8'h21}, "R6 status busy");

        // R4 command while busy ignored
        host_write(8'h00, 32'h000470FF);
        chk("R4 no doorbell", {31'h0, ctl_doorbell}, 32'h0);
        chk("R4 code kept", {24'h0, ctl_cmd_code}, 32'h80);
        chk("R4 size kept", {24'h0, ctl_cmd_size}, 32'h0C);
        host_read(8'h04, 1'b0, {16'h0, INIT, 8'h21}, "R4 status sub kept");

        // controller writes the response, then completes OK
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            ctl_rsp_we = 1'b1; ctl_rsp_idx = 2'(k); ctl_rsp_data = rsp[k];
        end
        @(negedge clk);
        ctl_rsp_we = 1'b0;
        ctl_finish(1'b0, i1, i2);
        chk("R8 irq pulse", {31'h0, i1}, 32'h1);
        chk("R8 irq single cycle", {31'h0, i2}, 32'h0);
        host_read(8'h04, 1'b0, {16'h0, INIT, 8'h20}, "R7 status done ok");

        // R9 response reads
        for (int k = 0; k < 4; k++) host_read(8'h90 + 8'(4*k), 1'b0, rsp[k], "R9 word");
        for (int n = 0; n < 16; n++)
            host_read(8'h90 + 8'(n), 1'b1, {24'h0, rsp[n/4][8*(n%4) +: 8]}, "R9 byte");

        // R7 failing command without ioc
        host_write(8'h00, 32'h00045033);
        @(negedge clk);
        ctl_err_we = 1'b1; ctl_err_code = 8'h33;
        @(negedge clk);
        ctl_err_we = 1'b0;
        ctl_finish(1'b1, i1, i2);
        chk("R8 no irq without flag", {31'h0, i1 | i2}, 32'h0);
        host_read(8'h04, 1'b0, {8'h00, 8'h33, INIT, 8'h52}, "R7 status error");

        // R10 new command clears error
        host_write(8'h00, 32'h00001001);
        host_read(8'h04, 1'b0, {16'h0, INIT, 8'h11}, "R10 status cleared");
        ctl_finish(1'b0, i1, i2);

        // R11 done while idle
        ctl_finish(1'b1, i1, i2);
        chk("R11 no irq", {31'h0, i1 | i2}, 32'h0);
        host_read(8'h04, 1'b0, {16'h0, INIT, 8'h10}, "R11 status unchanged");

        repeat (3) @(negedge clk);
        chk("R6 reads drained", 32'(exp_q.size()), 32'h0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule